// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. One is indexed by a shift register that holds the outcomes of the most recent branches across the whole program. The other is a two-level scheme: a per-address table holds each branch's own recent outcome pattern, and that pattern selects a 3-bit saturating counter. A third table of 2-bit saturating counters, indexed by the branch address, picks which of the two answers becomes the final prediction.

Fetch presents an address on the prediction port. The final prediction, both component predictions and the chooser's selection are combinational reads of the tables. When a branch resolves, the pipeline presents its address and outcome on the update port for one cycle. All tables and histories then train on that clock edge. The caller drops the instruction-alignment bits, so the address ports carry only the index bits. Table sizes are parameters. The defaults give a 4096-entry chooser, a 12-bit global history, a 1024-entry local history table with 10-bit patterns, and 1024 local counters.

Top module: `tournament_bp`

## Requirements
- R1: Reset clears the global history and every local history entry to zero. It sets every global counter to 1, every local counter to 3 and every chooser counter to 2. Every address then predicts not-taken, and the global component is selected.
- R2: `pred_global` is bit 1 of the 2-bit global counter indexed by the global history. Bit 0 of the history holds the newest outcome.
- R3: `pred_local` is bit 2 of the 3-bit local counter indexed by the local history entry. That entry is selected by the low `LT_W` address bits.
- R4: `pred_sel_global` is bit 1 of the chooser counter indexed by the low `CH_W` address bits. `pred_taken` equals `pred_global` when that bit is 1 and `pred_local` otherwise.
- R5: On an update, the global counter at the pre-update history moves one step toward the outcome: up if taken, down if not. It saturates at 0 and 3.
- R6: On an update, the local counter at the branch's pre-update local pattern moves one step toward the outcome and saturates at 0 and 7.
- R7: On an update, the outcome is shifted into bit 0 of both the global history and the branch's local history entry, and the oldest bit is dropped.
- R8: The chooser entry of the updated address changes only when the two component predictions for that address disagree. It then moves one step toward 3 if the global component was right, or toward 0 if the local component was right, and it saturates.
- R9: While `upd_valid` is low, no table or history changes, whatever the other update inputs carry.
- R10: An update affects the predictions from the clock edge that accepts it. A prediction read in the same cycle still sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Index bits of the fetch address |
| pred_taken | output | 1 | Final direction prediction |
| pred_global | output | 1 | Global component prediction |
| pred_local | output | 1 | Local component prediction |
| pred_sel_global | output | 1 | Chooser selects the global component |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Index bits of the resolved branch address |
| upd_taken | input | 1 | Resolved outcome |

## Verification
The prediction outputs are combinational in `pred_pc` and the stored state. The bench therefore reads them one nanosecond after it changes `pred_pc`, on a falling clock edge. An update is accepted at the rising edge where `upd_valid` is high and becomes visible one cycle later. The bench drives each update on a falling edge and applies it to its own model at the following rising edge. It then sweeps every prediction address over the next cycles, so each result is compared in the first cycle where it is due. Idle cycles with changing update inputs but no valid strobe are followed by a further sweep. That sweep shows that no state moved.

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int GH_W = 12,
  parameter int CH_W = 12,
  parameter int LT_W = 10,
  parameter int LH_W = 10,
  localparam int PC_W = (CH_W > LT_W) ? CH_W : LT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  output logic            pred_sel_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int GN  = 1 << GH_W;
  localparam int CN  = 1 << CH_W;
  localparam int LTN = 1 << LT_W;
  localparam int LN  = 1 << LH_W;

  logic [1:0]      gc   [GN];
  logic [2:0]      lc   [LN];
  logic [LH_W-1:0] lht  [LTN];
  logic [1:0]      ch   [CN];
  logic [GH_W-1:0] ghist;

  function automatic logic [1:0] step2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    else    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  function automatic logic [2:0] step3(input logic [2:0] v, input logic up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    else    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  logic [LH_W-1:0] p_pat, u_pat;
  logic [CH_W-1:0] u_ci;
  logic [LT_W-1:0] u_li;
  logic            u_g, u_l;

  assign p_pat           = lht[pred_pc[LT_W-1:0]];
  assign pred_global     = gc[ghist][1];
  assign pred_local      = lc[p_pat][2];
  assign pred_sel_global = ch[pred_pc[CH_W-1:0]][1];
  assign pred_taken      = pred_sel_global ? pred_global : pred_local;

  assign u_ci  = upd_pc[CH_W-1:0];
  assign u_li  = upd_pc[LT_W-1:0];
  assign u_pat = lht[u_li];
  assign u_g   = gc[ghist][1];
  assign u_l   = lc[u_pat][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < GN; i++)  gc[i]  <= 2'd1;
      for (int i = 0; i < LN; i++)  lc[i]  <= 3'd3;
      for (int i = 0; i < LTN; i++) lht[i] <= '0;
      for (int i = 0; i < CN; i++)  ch[i]  <= 2'd2;
    end else if (upd_valid) begin
      gc[ghist]  <= step2(gc[ghist], upd_taken);
      lc[u_pat]  <= step3(lc[u_pat], upd_taken);
      lht[u_li]  <= {u_pat[LH_W-2:0], upd_taken};
      ghist      <= {ghist[GH_W-2:0], upd_taken};
      if (u_g != u_l)
        ch[u_ci] <= step2(ch[u_ci], u_g == upd_taken);
    end
  end
endmodule

// File: rtl/tournament_bp_checks.sv
module tournament_bp_checks #(
  parameter int GH_W = 12,
  parameter int CH_W = 12,
  localparam int GN = 1 << GH_W,
  localparam int CN = 1 << CH_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic            pred_taken,
  input logic            pred_global,
  input logic            pred_local,
  input logic [GH_W-1:0] ghist,
  input logic            u_g,
  input logic            u_l,
  input logic [CH_W-1:0] u_ci,
  input logic [1:0]      gc [GN],
  input logic [1:0]      ch [CN]
);
  a_r9_idle_history: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  a_r7_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist[0] == $past(upd_taken)) && (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));

  a_r8_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (u_g == u_l)) |=> ch[$past(u_ci)] == $past(ch[u_ci]));

  a_r5_saturate_top: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && (gc[ghist] == 2'd3)) |=> gc[$past(ghist)] == 2'd3);

  a_r4_agree_out: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global == pred_local) |-> (pred_taken == pred_global));
endmodule

bind tournament_bp tournament_bp_checks #(.GH_W(GH_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
  .ghist(ghist), .u_g(u_g), .u_l(u_l), .u_ci(u_ci), .gc(gc), .ch(ch)
);

// File: tb/tb_tournament_bp.sv
`timescale 1ns/1ps
module tb_tournament_bp;
  localparam int GH_W = 3, CH_W = 3, LT_W = 2, LH_W = 3;
  localparam int PC_W = 3;
  localparam int GN = 1 << GH_W, CN = 1 << CH_W, LTN = 1 << LT_W, LN = 1 << LH_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_taken, pred_global, pred_local, pred_sel_global;

  int tests = 0, fails = 0;
  bit done = 0;

  int mg [GN];
  int ml [LN];
  int mlh [LTN];
  int mch [CN];
  int mgh;

  always #5 clk = ~clk;

  tournament_bp #(.GH_W(GH_W), .CH_W(CH_W), .LT_W(LT_W), .LH_W(LH_W)) dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local),
    .pred_sel_global(pred_sel_global), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken));

  task automatic chk(input string tag, input int p, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pc=%0d actual=%0b expected=%0b", tag, p, act, exp);
    end
  endtask

  task automatic model_reset();
    mgh = 0;
    for (int i = 0; i < GN; i++)  mg[i] = 1;
    for (int i = 0; i < LN; i++)  ml[i] = 3;
    for (int i = 0; i < LTN; i++) mlh[i] = 0;
    for (int i = 0; i < CN; i++)  mch[i] = 2;
  endtask

  task automatic sweep(input string phase);
    for (int p = 0; p < (1 << PC_W); p++) begin
      logic eg, el, es;
      @(negedge clk);
      pred_pc = PC_W'(p);
      #1;
      eg = mg[mgh] >= 2;
      el = ml[mlh[p % LTN]] >= 4;
      es = mch[p % CN] >= 2;
      chk({phase, " R2/R5/R7 global"}, p, pred_global, eg);
      chk({phase, " R3/R6 local"}, p, pred_local, el);
      chk({phase, " R4/R8 select"}, p, pred_sel_global, es);
      chk({phase, " R4 final R10"}, p, pred_taken, es ? eg : el);
    end
  endtask

  task automatic update(input int p, input bit t);
    int li, pat, gp, lp;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = PC_W'(p); upd_taken = t;
    li = p % LTN; pat = mlh[li];
    gp = (mg[mgh] >= 2); lp = (ml[pat] >= 4);
    @(posedge clk);
    #1 upd_valid = 1'b0;
    if (gp != lp) begin
      if (gp == t) mch[p % CN] = (mch[p % CN] == 3) ? 3 : mch[p % CN] + 1;
      else         mch[p % CN] = (mch[p % CN] == 0) ? 0 : mch[p % CN] - 1;
    end
    if (t) begin
      mg[mgh] = (mg[mgh] == 3) ? 3 : mg[mgh] + 1;
      ml[pat] = (ml[pat] == 7) ? 7 : ml[pat] + 1;
    end else begin
      mg[mgh] = (mg[mgh] == 0) ? 0 : mg[mgh] - 1;
      ml[pat] = (ml[pat] == 0) ? 0 : ml[pat] - 1;
    end
    mlh[li] = ((pat << 1) | int'(t)) % LN;
    mgh     = ((mgh << 1) | int'(t)) % GN;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 reset");

    // loop-like branch: seven taken, one exit
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 8; k++) begin
        update(5, k != 7);
        sweep("loop");
      end

    // alternating branch pulls local and global apart
    for (int k = 0; k < 12; k++) begin
      update(2, k[0]);
      sweep("alt");
    end

    // saturate downward at several addresses
    for (int k = 0; k < 10; k++) begin
      update(k % 4, 1'b0);
      sweep("down");
    end

    // pseudo-random mix
    begin
      logic [7:0] lf = 8'hA5;
      for (int k = 0; k < 120; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        update(int'(lf[2:0]), lf[6] | lf[1]);
        sweep("mix");
      end
    end

    // R9: update inputs move but valid stays low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      upd_pc = PC_W'(k); upd_taken = k[0];
    end
    sweep("R9 idle");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule